// File: doc/BRIEF.md
# Display Link Training Controller

This controller brings up a display link of up to four lanes. A start pulse samples the sink's highest link rate, its largest lane count, the payload bandwidth that must be carried and whether the sink can use enhanced framing. From these it picks a link rate and lane count and tells the sink which it picked. It then runs two training phases. In the clock-recovery phase it sends training pattern 1, and in the equalisation phase it sends pattern 2. Between status reads, it keeps changing the per-lane swing and pre-emphasis levels to follow what the sink asks for.

All traffic to the sink goes through a simple command port that stands in for the auxiliary-channel sequencer. Each request is a register write of up to four bytes or a read of up to six bytes. It is held until the port acknowledges it. If a phase fails at 270000 kHz, the controller picks the lane count again for 162000 kHz and starts over. A failure at 162000 kHz ends the sequence as failed. In every case the controller finishes by writing pattern 0 to the sink, and it then reports the outcome and the last configuration it used.

Top module: `link_train_ctrl`

## Requirements
- R1: The starting rate is 270000 kHz if `sink_max_khz` is at least 270000, and 162000 kHz otherwise. If `sink_max_khz` is below 162000, no link configuration is written: the controller writes pattern 0 and reports failed.
- R2: The lane count starts at `sink_max_lanes` (1, 2 or 4). It is halved while (lanes/2)·rate > `data_khz`. After that, a 270000 kHz start drops to 162000 kHz if 162000·lanes > `data_khz`.
- R3: The configuration is written with one 2-byte write at address 0x100. Byte 0 is the rate code: 0x0A for 270000 kHz, 0x06 for 162000 kHz. Byte 1 is the lane count, with bit 7 set when `enh_cap` is 1.
- R4: Clock recovery first writes pattern 1 to address 0x102 (1 byte). It then repeats three steps: write the four lane bytes at 0x103, wait exactly CR_WAIT cycles, and read 6 status bytes at 0x202. The first lane write of each attempt carries all zero levels.
- R5: The status nibble of lane i sits in status byte i/2, low nibble for even lanes and high nibble for odd lanes; bit 0 is CR-done, bit 1 EQ-done and bit 2 symbol-lock. The adjust nibble sits in byte 4+i/2 with the same packing: swing in bits 1:0, pre-emphasis in bits 3:2. Each lane byte written is pre<<3 | swing, plus bit 2 when swing is 3 and bit 5 when pre-emphasis is 3. Lanes at or above the lane count get zero. `drv_swing` and `drv_pre` carry two bits per lane.
- R6: Clock recovery passes when every active lane reports CR-done. It fails at once if the lowest failing lane already has swing 3. It also fails once the try count reaches CR_TRIES; that count restarts whenever the lane 0 swing changes.
- R7: Equalisation writes pattern 2, then repeats two steps: wait EQ_WAIT cycles and read the status. After every read it rewrites the lane bytes. It passes when bit 0 of status byte 2 is set and every active lane has CR-done, EQ-done and symbol-lock.
- R8: Equalisation fails if any active lane lacks CR-done, or after EQ_TRIES status reads.
- R9: A failed phase at 270000 kHz restarts at 162000 kHz, with the lane count picked again from `sink_max_lanes`. A failed phase at 162000 kHz ends the sequence as failed.
- R10: The sequence always ends by writing pattern 0. When that write is acknowledged, `done` pulses for one cycle and exactly one of `trained`/`failed` is set. `tx_pattern` is 0 at that point. `link_fast` and `link_lanes` keep the last configuration.
- R11: `cmd_req` and all request fields stay unchanged until `cmd_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin training (pulse while idle) |
| sink_max_khz | input | 20 | Sink's highest link rate in kHz |
| sink_max_lanes | input | 3 | Sink's largest lane count (1, 2, 4) |
| data_khz | input | 32 | Required payload bandwidth, in lane·kHz |
| enh_cap | input | 1 | Sink supports enhanced framing |
| cmd_req | output | 1 | Command request to the sink port |
| cmd_wr | output | 1 | 1 for write, 0 for read |
| cmd_addr | output | 12 | Sink register address |
| cmd_len | output | 3 | Byte count |
| cmd_wdata | output | 32 | Write bytes, byte 0 in bits 7:0 |
| cmd_ack | input | 1 | Command complete (one cycle) |
| cmd_rdata | input | 48 | Read bytes, valid with `cmd_ack` |
| tx_pattern | output | 2 | Local training pattern (0 off, 1, 2) |
| drv_swing | output | 8 | Swing level per lane, 2 bits each |
| drv_pre | output | 8 | Pre-emphasis level per lane, 2 bits each |
| link_fast | output | 1 | 1 when 270000 kHz is in use |
| link_lanes | output | 3 | Lane count in use |
| done | output | 1 | One-cycle end-of-training pulse |
| trained | output | 1 | Link trained |
| failed | output | 1 | Training failed |

## Verification
The assertions assume three things about the inputs. First, `sink_max_lanes` is always 1, 2 or 4. Second, the sink capability inputs, `data_khz` and `enh_cap` stay constant from `start` until `done`. Third, `cmd_ack` is raised only while `cmd_req` is high. The bench's sink model holds these inputs for the whole of each run and answers every request one cycle after first seeing it. It draws lane counts only from the three legal values, and it builds each status reply from a per-rate pass count and an adjust-request mode, so each scenario has a known number of reads.

// File: rtl/link_train_ctrl.sv
module link_train_ctrl #(
  parameter int CR_WAIT  = 100,
  parameter int EQ_WAIT  = 400,
  parameter int CR_TRIES = 5,
  parameter int EQ_TRIES = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [19:0] sink_max_khz,
  input  logic [2:0]  sink_max_lanes,
  input  logic [31:0] data_khz,
  input  logic        enh_cap,
  output logic        cmd_req,
  output logic        cmd_wr,
  output logic [11:0] cmd_addr,
  output logic [2:0]  cmd_len,
  output logic [31:0] cmd_wdata,
  input  logic        cmd_ack,
  input  logic [47:0] cmd_rdata,
  output logic [1:0]  tx_pattern,
  output logic [7:0]  drv_swing,
  output logic [7:0]  drv_pre,
  output logic        link_fast,
  output logic [2:0]  link_lanes,
  output logic        done,
  output logic        trained,
  output logic        failed
);
  localparam int MAXW = (CR_WAIT > EQ_WAIT) ? CR_WAIT : EQ_WAIT;
  localparam int WW   = $clog2(MAXW + 1);
  localparam int MAXT = (CR_TRIES > EQ_TRIES) ? CR_TRIES : EQ_TRIES;
  localparam int TW   = $clog2(MAXT + 2);
  localparam logic [31:0] RATE_HI = 32'd270000;
  localparam logic [31:0] RATE_LO = 32'd162000;

  typedef enum logic [2:0] {S_IDLE, S_SEL, S_CFG, S_TP, S_LANE, S_WAIT, S_STAT, S_EVAL} state_t;
  state_t st;

  logic          fast, phase, ok, eq_ok, eq_go;
  logic [2:0]    lanes;
  logic [1:0]    pat, vref;
  logic [47:0]   stat;
  logic [15:0]   conf, conf_nx;
  logic [TW-1:0] tries, tn_cr;
  logic [WW-1:0] wcnt;
  logic          cr_all, eq_all, cr_lost, abort_cr, seen;
  logic [31:0]   lane_bytes;
  logic          unused_bits;

  wire [31:0] rate     = fast ? RATE_HI : RATE_LO;
  wire [31:0] half_cov = {29'b0, lanes >> 1} * rate;
  wire [31:0] lo_cov   = {29'b0, lanes} * RATE_LO;
  assign unused_bits = ^stat[31:17];

  always_comb begin
    cr_all = 1'b1; eq_all = stat[16]; cr_lost = 1'b0; abort_cr = 1'b0; seen = 1'b0;
    conf_nx = '0; lane_bytes = '0;
    for (int i = 0; i < 4; i++) begin
      if (3'(i) < lanes) begin
        cr_all  &= stat[4*i];
        eq_all  &= &stat[4*i +: 3];
        cr_lost |= !stat[4*i];
        conf_nx[4*i +: 4] = stat[32+4*i +: 4];
        if (!stat[4*i] && !seen) begin
          seen = 1'b1;
          abort_cr = (conf[4*i +: 2] == 2'd3);
        end
      end
      lane_bytes[8*i +: 8] = {2'b0, conf[4*i+2 +: 2] == 2'd3, conf[4*i+2 +: 2],
                              conf[4*i +: 2] == 2'd3, conf[4*i +: 2]};
    end
    tn_cr = ((conf[1:0] != vref) ? '0 : tries) + 1'b1;
  end

  always_comb begin
    cmd_wr = 1'b1; cmd_addr = '0; cmd_len = '0; cmd_wdata = '0;
    case (st)
      S_CFG:  begin cmd_addr = 12'h100; cmd_len = 3'd2;
                    cmd_wdata = {16'b0, enh_cap, 4'b0, lanes, fast ? 8'h0A : 8'h06}; end
      S_TP:   begin cmd_addr = 12'h102; cmd_len = 3'd1; cmd_wdata = {30'b0, pat}; end
      S_LANE: begin cmd_addr = 12'h103; cmd_len = 3'd4; cmd_wdata = lane_bytes; end
      S_STAT: begin cmd_wr = 1'b0; cmd_addr = 12'h202; cmd_len = 3'd6; end
      default: ;
    endcase
  end

  assign cmd_req    = (st == S_CFG) || (st == S_TP) || (st == S_LANE) || (st == S_STAT);
  assign tx_pattern = pat;
  assign link_fast  = fast;
  assign link_lanes = lanes;
  for (genvar g = 0; g < 4; g++) begin : g_drv
    assign drv_swing[2*g +: 2] = conf[4*g +: 2];
    assign drv_pre[2*g +: 2]   = conf[4*g+2 +: 2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; fast <= 1'b0; lanes <= 3'd1; pat <= '0; phase <= 1'b0; ok <= 1'b0;
      stat <= '0; conf <= '0; vref <= '0; tries <= '0; wcnt <= '0;
      eq_ok <= 1'b0; eq_go <= 1'b0; done <= 1'b0; trained <= 1'b0; failed <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          trained <= 1'b0; failed <= 1'b0; conf <= '0;
          fast  <= ({12'b0, sink_max_khz} >= RATE_HI);
          lanes <= sink_max_lanes;
          if ({12'b0, sink_max_khz} < RATE_LO) begin
            ok <= 1'b0; pat <= '0; st <= S_TP;
          end else st <= S_SEL;
        end
        S_SEL:
          if (half_cov > data_khz) lanes <= lanes >> 1;
          else if (fast && lo_cov > data_khz) fast <= 1'b0;
          else st <= S_CFG;
        S_CFG: if (cmd_ack) begin
          stat <= '0; conf <= '0; vref <= '0; tries <= '0; phase <= 1'b0; pat <= 2'd1;
          st <= S_TP;
        end
        S_TP: if (cmd_ack) begin
          if (pat == 2'd0) begin
            done <= 1'b1; trained <= ok; failed <= !ok; st <= S_IDLE;
          end else if (!phase) begin
            conf <= conf_nx; st <= S_LANE;
          end else begin
            wcnt <= WW'(EQ_WAIT - 1); st <= S_WAIT;
          end
        end
        S_LANE: if (cmd_ack) begin
          if (!phase) begin
            wcnt <= WW'(CR_WAIT - 1); st <= S_WAIT;
          end else if (eq_ok) begin
            ok <= 1'b1; pat <= '0; st <= S_TP;
          end else if (eq_go) begin
            wcnt <= WW'(EQ_WAIT - 1); st <= S_WAIT;
          end else if (fast) begin
            fast <= 1'b0; lanes <= sink_max_lanes; conf <= '0; st <= S_SEL;
          end else begin
            ok <= 1'b0; pat <= '0; st <= S_TP;
          end
        end
        S_WAIT: if (wcnt == '0) st <= S_STAT; else wcnt <= wcnt - 1'b1;
        S_STAT: if (cmd_ack) begin stat <= cmd_rdata; st <= S_EVAL; end
        S_EVAL:
          if (!phase) begin
            vref <= conf[1:0]; tries <= tn_cr;
            if (cr_all) begin
              phase <= 1'b1; pat <= 2'd2; tries <= '0; st <= S_TP;
            end else if (abort_cr || tn_cr >= TW'(CR_TRIES)) begin
              if (fast) begin
                fast <= 1'b0; lanes <= sink_max_lanes; conf <= '0; st <= S_SEL;
              end else begin
                ok <= 1'b0; pat <= '0; st <= S_TP;
              end
            end else begin
              conf <= conf_nx; st <= S_LANE;
            end
          end else begin
            tries <= tries + 1'b1;
            eq_ok <= eq_all;
            eq_go <= !eq_all && !cr_lost && ((tries + 1'b1) < TW'(EQ_TRIES));
            conf  <= conf_nx;
            st    <= S_LANE;
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R11
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_addr) && $stable(cmd_wdata) && $stable(cmd_wr)));
  // R10
  end_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tx_pattern == 2'd0 && (trained != failed)));
  // R2
  lane_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(link_lanes) && link_lanes <= 3'd4);
  // R5
  idle_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_lanes != 3'd4) |-> (drv_swing[7:4] == 4'd0 && drv_pre[7:4] == 4'd0));
  // R8
  eq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase && st == S_WAIT) |-> (tries < TW'(EQ_TRIES)));
endmodule

// File: tb/link_train_ctrl_tb_top.sv
`timescale 1ns/1ps
module link_train_ctrl_tb_top;
  localparam int CRW = 100;
  localparam int EQW = 400;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, start, enh_cap, cmd_req, cmd_wr, cmd_ack, link_fast, done, trained, failed;
  logic [19:0] sink_max_khz;
  logic [2:0]  sink_max_lanes, cmd_len, link_lanes;
  logic [31:0] data_khz, cmd_wdata;
  logic [11:0] cmd_addr;
  logic [47:0] cmd_rdata;
  logic [1:0]  tx_pattern;
  logic [7:0]  drv_swing, drv_pre;

  link_train_ctrl #(.CR_WAIT(CRW), .EQ_WAIT(EQW), .CR_TRIES(5), .EQ_TRIES(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sink_max_khz(sink_max_khz),
    .sink_max_lanes(sink_max_lanes), .data_khz(data_khz), .enh_cap(enh_cap),
    .cmd_req(cmd_req), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .cmd_wdata(cmd_wdata), .cmd_ack(cmd_ack), .cmd_rdata(cmd_rdata),
    .tx_pattern(tx_pattern), .drv_swing(drv_swing), .drv_pre(drv_pre),
    .link_fast(link_fast), .link_lanes(link_lanes), .done(done),
    .trained(trained), .failed(failed));

  int n_chk = 0, n_fail = 0;
  int need_cr[2], need_eq[2];
  int adj_mode = 0;
  bit crlost = 0;
  int cyc = 0, hold = 0, last_pat = 0, pat_writes = 0, n_cfg = 0, cfg_b0 = 0, cfg_b1 = 0;
  int cr_reads = 0, eq_reads = 0, lw_eq = 0, prev_cr = 0, prev_eq = 0, prev_lw_eq = 0;
  int last_wr_cyc = 0, gap_err = 0, fi = 0, k = 0;
  logic [31:0] last_lane, first_cr_lane;
  logic [47:0] s;
  logic [3:0]  ln, ad;
  bit pass;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // sink model: acknowledges each request one cycle after first seeing it
  initial begin
    cmd_ack = 1'b0; cmd_rdata = '0;
    forever begin
      @(negedge clk);
      cyc++;
      cmd_ack = 1'b0;
      if (cmd_req) begin
        if (hold == 0 && !cmd_wr && (cyc - last_wr_cyc) != ((last_pat == 2) ? EQW : CRW) + 1)
          gap_err++;
        if (hold == 1) begin
          hold = 0;
          cmd_ack = 1'b1;
          case (cmd_addr)
            12'h100: begin
              n_cfg++; cfg_b0 = int'(cmd_wdata[7:0]); cfg_b1 = int'(cmd_wdata[15:8]);
              prev_cr = cr_reads; prev_eq = eq_reads; prev_lw_eq = lw_eq;
              cr_reads = 0; eq_reads = 0; lw_eq = 0;
            end
            12'h102: begin last_pat = int'(cmd_wdata[1:0]); pat_writes++; end
            12'h103: begin
              if (last_pat == 1 && cr_reads == 0) first_cr_lane = cmd_wdata;
              if (last_pat == 2) lw_eq++;
              last_lane = cmd_wdata;
            end
            12'h202: begin
              fi = (cfg_b0 == 8'h0A) ? 1 : 0;
              s = '0;
              if (last_pat == 1) begin
                cr_reads++; k = cr_reads; pass = (k >= need_cr[fi]);
                ln = pass ? 4'h1 : 4'h0;
              end else begin
                eq_reads++; k = eq_reads; pass = (k >= need_eq[fi]);
                ln = crlost ? 4'h0 : (pass ? 4'h7 : 4'h1);
                s[16] = pass && !crlost;
              end
              case (adj_mode)
                1: ad = 4'h3;
                2: ad = (k >= 2) ? 4'h2 : 4'(k);
                3: ad = 4'hD;
                default: ad = 4'h0;
              endcase
              for (int i = 0; i < 4; i++) begin
                s[4*i +: 4] = ln;
                s[32+4*i +: 4] = (adj_mode == 2 && i != 0) ? 4'h0 : ad;
              end
              cmd_rdata = s;
            end
            default: ;
          endcase
          if (cmd_wr) last_wr_cyc = cyc;
        end else hold = 1;
      end
    end
  end

  function automatic void exp_sel(input int mx, input int l0, input int d, output int f, output int l);
    int r;
    f = (mx >= 270000) ? 1 : 0;
    l = l0;
    r = f ? 270000 : 162000;
    while ((l >> 1) * r > d) l = l >> 1;
    if (f == 1 && 162000 * l > d) f = 0;
  endfunction

  task automatic sink_cfg(input int cr_lo, input int cr_hi, input int eq_lo, input int eq_hi,
                          input int am, input bit cl);
    need_cr[0] = cr_lo; need_cr[1] = cr_hi; need_eq[0] = eq_lo; need_eq[1] = eq_hi;
    adj_mode = am; crlost = cl;
  endtask

  task automatic run(input int mx, input int l0, input int d, input bit e);
    int t;
    pat_writes = 0; n_cfg = 0; cr_reads = 0; eq_reads = 0; lw_eq = 0;
    prev_cr = 0; prev_eq = 0; prev_lw_eq = 0; last_pat = 0;
    last_lane = '0; first_cr_lane = 32'hFFFF_FFFF;
    sink_max_khz = 20'(mx); sink_max_lanes = 3'(l0); data_khz = 32'(d); enh_cap = e;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk("R10 done seen", int'(done), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int fe, le;
    int mxs[4] = '{162000, 200000, 270000, 300000};
    int lns[3] = '{1, 2, 4};
    int ds[6]  = '{100000, 162000, 300000, 324000, 600000, 1000000};
    rst_n = 1'b0; start = 1'b0; enh_cap = 1'b0;
    sink_max_khz = '0; sink_max_lanes = 3'd1; data_khz = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset done", int'(done), 0);
    chk("R10 reset trained/failed", int'({trained, failed}), 0);
    chk("R11 reset cmd_req", int'(cmd_req), 0);
    chk("R4 reset tx_pattern", int'(tx_pattern), 0);

    // R1 R2 R3 sweep: sink passes at once
    sink_cfg(1, 1, 1, 1, 0, 0);
    foreach (mxs[a]) foreach (lns[b]) foreach (ds[c]) begin
      run(mxs[a], lns[b], ds[c], c[0]);
      exp_sel(mxs[a], lns[b], ds[c], fe, le);
      chk("R1 R2 rate", int'(link_fast), fe);
      chk("R2 lanes", int'(link_lanes), le);
      chk("R3 rate code", cfg_b0, fe ? 8'h0A : 8'h06);
      chk("R3 lane byte", cfg_b1, le | (c[0] ? 128 : 0));
      chk("R10 trained", int'(trained), 1);
      chk("R10 pattern off", last_pat * 4 + int'(tx_pattern), 0);
    end

    // R1 sink below lowest rate
    run(100000, 4, 100000, 0);
    chk("R1 failed", int'(failed), 1);
    chk("R1 no config", n_cfg, 0);
    chk("R1 pattern writes", pat_writes, 1);

    // R6 R9 CR try limit at high rate, fallback re-derives lanes
    sink_cfg(1, 99, 1, 1, 0, 0);
    run(270000, 4, 200000, 0);
    chk("R6 cr tries", prev_cr, 5);
    chk("R9 fallback rate", int'(link_fast), 0);
    chk("R9 fallback lanes", int'(link_lanes), 2);
    chk("R9 configs", n_cfg, 2);
    chk("R9 trained", int'(trained), 1);

    // R6 abort at max swing, R9 failure at lowest rate
    sink_cfg(99, 99, 1, 1, 1, 0);
    run(270000, 4, 700000, 0);
    chk("R6 abort hi", prev_cr, 2);
    chk("R6 abort lo", cr_reads, 2);
    chk("R9 failed", int'(failed), 1);
    chk("R10 last config lanes", int'(link_lanes), 4);
    chk("R10 last config rate", int'(link_fast), 0);
    chk("R10 final pattern", last_pat, 0);

    // R6 try count restart on lane 0 swing change
    sink_cfg(1, 99, 1, 1, 2, 0);
    run(270000, 4, 700000, 0);
    chk("R6 swing restart", prev_cr, 7);
    chk("R6 trained", int'(trained), 1);

    // R8 EQ iteration limit, R7 lane rewrite per read
    sink_cfg(1, 1, 1, 99, 0, 0);
    run(270000, 4, 700000, 0);
    chk("R8 eq reads", prev_eq, 6);
    chk("R7 eq lane writes", prev_lw_eq, 6);
    chk("R8 fallback trained", int'(trained), 1);

    // R8 CR lost during EQ
    sink_cfg(1, 1, 1, 1, 0, 1);
    run(270000, 4, 700000, 0);
    chk("R8 crlost hi", prev_eq, 1);
    chk("R8 crlost lo", eq_reads, 1);
    chk("R8 failed", int'(failed), 1);

    // R4 R5 level encoding: adjust pre 3 swing 1, two lanes
    sink_cfg(1, 2, 1, 1, 3, 0);
    run(270000, 2, 540000, 0);
    chk("R4 first lanes zero", int'(first_cr_lane), 0);
    chk("R5 lane bytes", int'(last_lane), 32'h0000_3939);
    chk("R5 drv_pre", int'(drv_pre), 8'h0F);
    chk("R5 drv_swing", int'(drv_swing), 8'h05);
    chk("R5 cr reads", cr_reads, 2);
    chk("R7 trained", int'(trained), 1);

    chk("R4 R7 wait before status", gap_err, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule